// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Data Unit

This block is the arithmetic heart of a 24-bit fixed-point audio datapath. Each cycle it can take two signed fractional operands, form their product, and clear, load, add into or subtract from one of two 56-bit accumulators. Every accumulator is laid out as 8 guard bits above a 24-bit high word and a 24-bit low word. The product of two fractions is doubled before it is used, so that the binary point of the product matches the binary point of the accumulator.

The result word is read through a registered port. The read path applies the selected scaling, rounds the value to 24 bits with round-half-to-even, and clamps it to the 24-bit range when the rounded value does not fit. A clamp on read sets a sticky limit indicator. Each operation updates a four-bit condition code from its result. An operation can optionally round the value it writes back to the accumulator.

Top module: `fmac_unit`

## Requirements
- R1: After a synchronous reset both accumulators hold zero, and `rd_data`, `cc_flags` and `lim_sticky` are all zero.
- R2: Opcode 01 (multiply) loads the addressed accumulator with twice the signed product of `opnd_a` and `opnd_b`, sign-extended to 56 bits. The new value is visible one cycle later.
- R3: Opcode 10 adds twice the product to the addressed accumulator and opcode 11 subtracts it, with the result wrapping modulo 2^56. Opcode 00 clears the addressed accumulator and leaves the flags at 4'b0010.
- R4: Only the accumulator named by `op_acc` changes, and only in a cycle where `op_valid` is high. Operand and opcode values presented with `op_valid` low have no effect.
- R5: When `rd_en` is high, `rd_data` takes on the next cycle the rounded word of accumulator `rd_acc`, as it stood before any write at that same edge. `scale_mode` sets the rounding bit: 00 and 11 select no scaling (bit 24), 01 selects scale down (bit 25) and 10 selects scale up (bit 23). An exact half rounds to the even result. With `rd_en` low, `rd_data` holds its value.
- R6: A rounded read value above 2^23-1 reads as 24'h7FFFFF, and one below -2^23 reads as 24'h800000.
- R7: `lim_sticky` goes high the cycle after a read that clamped. It then stays high until reset.
- R8: `cc_flags` is {E, V, Z, N} (bit 3 down to bit 0). It is registered on the cycle after an operation with `op_valid` high and held otherwise. N is bit 55 of the value written and Z is high when that value is zero.
- R9: V is high when a 56-bit addition or subtraction overflows in the signed sense. It is low for multiply and clear.
- R10: With `rnd_wr` high, the value written is the result rounded half-to-even at the bit chosen by `scale_mode`, with all lower bits cleared.
- R11: E is high when the operation result before write rounding, arithmetically shifted right by the rounding bit index, does not fit in 24 signed bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 2 | 00 clear, 01 multiply, 10 multiply-add, 11 multiply-subtract |
| op_acc | input | 1 | Accumulator addressed by the operation |
| opnd_a | input | 24 | Signed fractional operand |
| opnd_b | input | 24 | Signed fractional operand |
| rnd_wr | input | 1 | Round the value written by this operation |
| scale_mode | input | 2 | 00 none, 01 down, 10 up, 11 none |
| rd_en | input | 1 | Read request |
| rd_acc | input | 1 | Accumulator to read |
| rd_data | output | 24 | Scaled, rounded and clamped result word |
| cc_flags | output | 4 | {E, V, Z, N} condition code |
| lim_sticky | output | 1 | Sticky clamp indicator |

## Verification
The bench targets exact-half fractions that sit above both an even and an odd kept bit. A design that rounds half up, or that truncates, returns an odd word or a word one step short. Minus one times minus one makes a product of +1.0. A design that does not double the product, or that loses the sign, gives a wrong read, where the correct read is a clamp to 7FFFFF together with the E flag. A run of 256 full-scale accumulations wraps the 56-bit register. It must raise V exactly on the last step, never earlier. A read with the scale-up setting after a rounded write shows whether the low bits were really cleared, since an unrounded store would read 3 instead of 4.

// File: rtl/fmac_pkg.sv
package fmac_pkg;

    localparam int FM_DW   = 24;
    localparam int FM_EXTW = 8;
    localparam int FM_NACC = 2;

    typedef enum logic [1:0] {
        OP_CLR  = 2'b00,
        OP_MPY  = 2'b01,
        OP_MAC  = 2'b10,
        OP_MSUB = 2'b11
    } mac_op_e;

    typedef enum logic [1:0] {
        SC_NONE = 2'b00,
        SC_DOWN = 2'b01,
        SC_UP   = 2'b10,
        SC_RSVD = 2'b11
    } scale_e;

    typedef struct packed {
        logic ext;
        logic ovf;
        logic zero;
        logic neg;
    } cc_t;

    // Index of the scaling variant: 0 none, 1 down, 2 up.
    function automatic logic [1:0] scale_idx(scale_e s);
        case (s)
            SC_DOWN: return 2'd1;
            SC_UP:   return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    // Bit index of the lowest kept accumulator bit for a scaling variant.
    function automatic int round_pos(int dw, int idx);
        case (idx)
            1:       return dw + 1;
            2:       return dw - 1;
            default: return dw;
        endcase
    endfunction

endpackage

// File: rtl/fmac_product.sv
module fmac_product
    import fmac_pkg::*;
#(
    parameter int DW   = FM_DW,
    parameter int ACCW = FM_EXTW + 2 * FM_DW
) (
    input  logic [DW-1:0]   mul_a,
    input  logic [DW-1:0]   mul_b,
    output logic [ACCW-1:0] prod_acc
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0] raw;

    assign raw = $signed(mul_a) * $signed(mul_b);

    // Doubling aligns the product's binary point with the accumulator's.
    assign prod_acc = {{(ACCW-PW){raw[PW-1]}}, raw[PW-2:0], 1'b0};
endmodule

// File: rtl/fmac_limiter.sv
module fmac_limiter
    import fmac_pkg::*;
#(
    parameter int DW         = FM_DW,
    parameter int ACCW       = FM_EXTW + 2 * FM_DW,
    parameter int STORE_FORM = 0,
    parameter int OW         = (STORE_FORM != 0) ? ACCW : DW
) (
    input  logic [ACCW-1:0] acc_in,
    input  scale_e          scale,
    output logic [OW-1:0]   val_out,
    output logic            flag_out
);
    localparam int NMODE = 3;

    logic [OW-1:0] val_m  [NMODE];
    logic          flag_m [NMODE];
    logic [1:0]    sel;

    assign sel = scale_idx(scale);

    for (genvar m = 0; m < NMODE; m++) begin : g_mode
        localparam int P = round_pos(DW, m);

        logic [P-1:0] frac;
        logic         bump;

        assign frac = acc_in[P-1:0];
        // Half-to-even: an exact half goes up only when the kept LSB is odd.
        assign bump = (frac > {1'b1, {(P-1){1'b0}}})
                   || ((frac == {1'b1, {(P-1){1'b0}}}) && acc_in[P]);

        if (STORE_FORM != 0) begin : g_store
            assign val_m[m] = {acc_in[ACCW-1:P], {P{1'b0}}}
                            + {{(ACCW-P-1){1'b0}}, bump, {P{1'b0}}};
            assign flag_m[m] = ~((&acc_in[ACCW-1:P+DW-1]) | ~(|acc_in[ACCW-1:P+DW-1]));
        end else begin : g_read
            logic signed [ACCW-1:0] kept;
            logic [ACCW-1:0]        q;
            logic                   fits;

            assign kept = $signed(acc_in) >>> P;
            assign q    = kept + {{(ACCW-1){1'b0}}, bump};
            assign fits = (&q[ACCW-1:DW-1]) | ~(|q[ACCW-1:DW-1]);
            assign val_m[m] = fits ? q[DW-1:0]
                            : (q[ACCW-1] ? {1'b1, {(DW-1){1'b0}}}
                                         : {1'b0, {(DW-1){1'b1}}});
            assign flag_m[m] = ~fits;
        end
    end

    always_comb begin
        val_out  = val_m[0];
        flag_out = flag_m[0];
        case (sel)
            2'd1: begin
                val_out  = val_m[1];
                flag_out = flag_m[1];
            end
            2'd2: begin
                val_out  = val_m[2];
                flag_out = flag_m[2];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fmac_acc_bank.sv
module fmac_acc_bank #(
    parameter int ACCW = 56,
    parameter int NACC = 2,
    parameter int SELW = $clog2(NACC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [SELW-1:0] wr_sel,
    input  logic [ACCW-1:0] wr_val,
    input  logic [SELW-1:0] op_sel,
    output logic [ACCW-1:0] op_val,
    input  logic [SELW-1:0] rd_sel,
    output logic [ACCW-1:0] rd_val
);
    logic [ACCW-1:0] bank [NACC];

    always_ff @(posedge clk) begin
        for (int g = 0; g < NACC; g++) begin
            if (rst) begin
                bank[g] <= '0;
            end else if (wr_en && (wr_sel == SELW'(g))) begin
                bank[g] <= wr_val;
            end
        end
    end

    assign op_val = bank[op_sel];
    assign rd_val = bank[rd_sel];
endmodule

// File: rtl/fmac_unit.sv
module fmac_unit
    import fmac_pkg::*;
#(
    parameter int DW   = FM_DW,
    parameter int EXTW = FM_EXTW,
    parameter int NACC = FM_NACC,
    localparam int ACCW = EXTW + 2 * DW,
    localparam int SELW = $clog2(NACC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [1:0]      op_code,
    input  logic [SELW-1:0] op_acc,
    input  logic [DW-1:0]   opnd_a,
    input  logic [DW-1:0]   opnd_b,
    input  logic            rnd_wr,
    input  logic [1:0]      scale_mode,
    input  logic            rd_en,
    input  logic [SELW-1:0] rd_acc,
    output logic [DW-1:0]   rd_data,
    output logic [3:0]      cc_flags,
    output logic            lim_sticky
);
    mac_op_e         op;
    scale_e          sc;
    logic [ACCW-1:0] cur_acc;
    logic [ACCW-1:0] src_acc;
    logic [ACCW-1:0] prod;
    logic [ACCW-1:0] res_raw;
    logic [ACCW-1:0] res_rnd;
    logic [ACCW-1:0] res_wr;
    logic            ovf;
    logic            ext_hit;
    logic [DW-1:0]   rd_word;
    logic            rd_sat;
    cc_t             cc_q;

    assign op = mac_op_e'(op_code);
    assign sc = scale_e'(scale_mode);

    fmac_product #(.DW(DW), .ACCW(ACCW)) u_prod (
        .mul_a    (opnd_a),
        .mul_b    (opnd_b),
        .prod_acc (prod)
    );

    fmac_acc_bank #(.ACCW(ACCW), .NACC(NACC), .SELW(SELW)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (op_valid),
        .wr_sel (op_acc),
        .wr_val (res_wr),
        .op_sel (op_acc),
        .op_val (cur_acc),
        .rd_sel (rd_acc),
        .rd_val (src_acc)
    );

    always_comb begin
        res_raw = '0;
        ovf     = 1'b0;
        case (op)
            OP_CLR: res_raw = '0;
            OP_MPY: res_raw = prod;
            OP_MAC: begin
                res_raw = cur_acc + prod;
                ovf = (cur_acc[ACCW-1] == prod[ACCW-1])
                   && (res_raw[ACCW-1] != cur_acc[ACCW-1]);
            end
            OP_MSUB: begin
                res_raw = cur_acc - prod;
                ovf = (cur_acc[ACCW-1] != prod[ACCW-1])
                   && (res_raw[ACCW-1] != cur_acc[ACCW-1]);
            end
            default: ;
        endcase
    end

    fmac_limiter #(.DW(DW), .ACCW(ACCW), .STORE_FORM(1), .OW(ACCW)) u_wr_lim (
        .acc_in   (res_raw),
        .scale    (sc),
        .val_out  (res_rnd),
        .flag_out (ext_hit)
    );

    assign res_wr = rnd_wr ? res_rnd : res_raw;

    fmac_limiter #(.DW(DW), .ACCW(ACCW), .STORE_FORM(0), .OW(DW)) u_rd_lim (
        .acc_in   (src_acc),
        .scale    (sc),
        .val_out  (rd_word),
        .flag_out (rd_sat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cc_q       <= '0;
            rd_data    <= '0;
            lim_sticky <= 1'b0;
        end else begin
            if (op_valid) begin
                cc_q <= '{ext: ext_hit, ovf: ovf, zero: (res_wr == '0), neg: res_wr[ACCW-1]};
            end
            if (rd_en) begin
                rd_data <= rd_word;
                if (rd_sat) begin
                    lim_sticky <= 1'b1;
                end
            end
        end
    end

    assign cc_flags = cc_q;
endmodule

// File: rtl/fmac_chk.sv
module fmac_chk #(
    parameter int DW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic          op_valid,
    input logic [1:0]    op_code,
    input logic          rd_en,
    input logic [DW-1:0] rd_data,
    input logic [3:0]    cc_flags,
    input logic          lim_sticky
);
    // R1
    rst_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rd_data == '0 && cc_flags == 4'b0000 && !lim_sticky));

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rd_en)) |-> $stable(rd_data));

    // R7
    lim_keep_chk: assert property (@(posedge clk) disable iff (rst)
        lim_sticky |=> lim_sticky);

    // R7
    lim_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(lim_sticky)) |-> $past(rd_en));

    // R8
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(op_valid)) |-> $stable(cc_flags));

    // R8
    nz_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cc_flags[0] && cc_flags[1]));

    // R3
    clr_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_valid) && $past(op_code) == 2'b00) |-> (cc_flags == 4'b0010));

    // R9
    ovf_src_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(cc_flags[2])) |-> $past(op_valid && op_code[1]));
endmodule

bind fmac_unit fmac_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .cc_flags   (cc_flags),
    .lim_sticky (lim_sticky)
);

// File: tb/sim_fmac_unit.sv
module sim_fmac_unit;
    logic        clk;
    logic        rst;
    logic        op_valid;
    logic [1:0]  op_code;
    logic        op_acc;
    logic [23:0] opnd_a;
    logic [23:0] opnd_b;
    logic        rnd_wr;
    logic [1:0]  scale_mode;
    logic        rd_en;
    logic        rd_acc;
    logic [23:0] rd_data;
    logic [3:0]  cc_flags;
    logic        lim_sticky;

    int n_run = 0;
    int n_bad = 0;
    bit done  = 0;

    fmac_unit u0 (
        .clk        (clk),
        .rst        (rst),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .op_acc     (op_acc),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .rnd_wr     (rnd_wr),
        .scale_mode (scale_mode),
        .rd_en      (rd_en),
        .rd_acc     (rd_acc),
        .rd_data    (rd_data),
        .cc_flags   (cc_flags),
        .lim_sticky (lim_sticky)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Behavioural reference state
    longint      m_acc [2];
    logic [23:0] m_rd;
    logic [3:0]  m_cc;
    logic        m_lim;

    function automatic longint w56(longint x);
        return (x <<< 8) >>> 8;
    endfunction

    function automatic int pos_of(logic [1:0] s);
        if (s == 2'b01) return 25;
        if (s == 2'b10) return 23;
        return 24;
    endfunction

    function automatic longint rq(longint v, int p);
        longint t = v >>> p;
        longint f = v - (t <<< p);
        longint h = 64'sd1 <<< (p - 1);
        if (f > h || (f == h && t[0])) t = t + 1;
        return t;
    endfunction

    function automatic bit out24(longint q);
        return (q > 64'sd8388607) || (q < -64'sd8388608);
    endfunction

    function automatic logic [23:0] lim24(longint q);
        if (q > 64'sd8388607) return 24'h7FFFFF;
        if (q < -64'sd8388608) return 24'h800000;
        return q[23:0];
    endfunction

    always @(posedge clk) begin
        longint q, cur, prod, sum, nv;
        int p;
        bit ovf, ext;
        if (rst) begin
            m_acc[0] = 0;
            m_acc[1] = 0;
            m_rd = '0;
            m_cc = '0;
            m_lim = 1'b0;
        end else begin
            p = pos_of(scale_mode);
            if (rd_en) begin
                q = rq(m_acc[rd_acc], p);
                m_rd = lim24(q);
                if (out24(q)) m_lim = 1'b1;
            end
            if (op_valid) begin
                cur  = m_acc[op_acc];
                prod = 2 * longint'($signed(opnd_a)) * longint'($signed(opnd_b));
                case (op_code)
                    2'b00:   sum = 0;
                    2'b01:   sum = prod;
                    2'b10:   sum = cur + prod;
                    default: sum = cur - prod;
                endcase
                nv  = w56(sum);
                ovf = (nv != sum);
                ext = out24(nv >>> p);
                if (rnd_wr) nv = w56(rq(nv, p) <<< p);
                m_cc = {ext, ovf, (nv == 0), (nv < 0)};
                m_acc[op_acc] = nv;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(rd_data === m_rd, "R5 model read word", longint'(rd_data), longint'(m_rd));
            chk(cc_flags === m_cc, "R8 model flags", longint'(cc_flags), longint'(m_cc));
            chk(lim_sticky === m_lim, "R7 model limit flag", longint'(lim_sticky), longint'(m_lim));
        end
    end

    task automatic do_op(input logic [1:0] c, input logic s, input logic [23:0] a,
                         input logic [23:0] b, input logic rw = 1'b0);
        op_code  = c;
        op_acc   = s;
        opnd_a   = a;
        opnd_b   = b;
        rnd_wr   = rw;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        rnd_wr   = 1'b0;
    endtask

    task automatic do_rd(input logic s, input logic [1:0] sc, output logic [23:0] w);
        rd_en      = 1'b1;
        rd_acc     = s;
        scale_mode = sc;
        @(negedge clk);
        rd_en      = 1'b0;
        scale_mode = 2'b00;
        w = rd_data;
    endtask

    initial begin
        logic [23:0] w;
        rst = 1'b1; op_valid = 0; op_code = 0; op_acc = 0; opnd_a = 0; opnd_b = 0;
        rnd_wr = 0; scale_mode = 0; rd_en = 0; rd_acc = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_data == 24'h0, "R1 reset rd_data", rd_data, 0);
        chk(cc_flags == 4'h0, "R1 reset flags", cc_flags, 0);
        chk(lim_sticky == 1'b0, "R1 reset limit", lim_sticky, 0);

        do_op(2'b01, 0, 24'h400000, 24'h400000);
        chk(cc_flags == 4'b0000, "R8 flags after multiply", cc_flags, 0);
        do_rd(0, 2'b00, w);
        chk(w == 24'h200000, "R2 half times half", w, 24'h200000);

        do_op(2'b10, 0, 24'h400000, 24'h400000);
        do_rd(0, 2'b00, w);
        chk(w == 24'h400000, "R3 accumulate", w, 24'h400000);
        do_op(2'b11, 0, 24'h400000, 24'h200000);
        do_rd(0, 2'b00, w);
        chk(w == 24'h300000, "R3 subtract", w, 24'h300000);

        do_op(2'b00, 1, 24'h123456, 24'h654321);
        chk(cc_flags == 4'b0010, "R8 zero flag after clear", cc_flags, 4'b0010);
        do_rd(0, 2'b00, w);
        chk(w == 24'h300000, "R4 other accumulator untouched", w, 24'h300000);
        do_rd(1, 2'b00, w);
        chk(w == 24'h000000, "R3 clear", w, 0);

        op_code = 2'b01; op_acc = 0; opnd_a = 24'h7FFFFF; opnd_b = 24'h7FFFFF;
        @(negedge clk);
        do_rd(0, 2'b00, w);
        chk(w == 24'h300000, "R4 no write without strobe", w, 24'h300000);
        chk(cc_flags == 4'b0010, "R8 flags hold", cc_flags, 4'b0010);

        do_op(2'b01, 1, 24'h000400, 24'h001000);
        do_rd(1, 2'b00, w);
        chk(w == 24'h000000, "R5 half to even zero", w, 0);
        do_op(2'b10, 1, 24'h001000, 24'h001000);
        do_rd(1, 2'b00, w);
        chk(w == 24'h000002, "R5 half stays even", w, 2);
        do_op(2'b10, 1, 24'h000800, 24'h001000);
        do_rd(1, 2'b00, w);
        chk(w == 24'h000004, "R5 half from odd goes up", w, 4);
        do_rd(1, 2'b01, w);
        chk(w == 24'h000002, "R5 scale down", w, 2);
        do_rd(1, 2'b10, w);
        chk(w == 24'h000007, "R5 scale up", w, 7);

        do_op(2'b01, 0, 24'h800000, 24'h800000);
        chk(cc_flags == 4'b1000, "R11 extension in use", cc_flags, 4'b1000);
        chk(lim_sticky == 1'b0, "R7 no clamp yet", lim_sticky, 0);
        do_rd(0, 2'b00, w);
        chk(w == 24'h7FFFFF, "R6 positive clamp", w, 24'h7FFFFF);
        chk(lim_sticky == 1'b1, "R7 limit set", lim_sticky, 1);
        do_rd(0, 2'b01, w);
        chk(w == 24'h400000, "R5 scale down avoids clamp", w, 24'h400000);
        chk(lim_sticky == 1'b1, "R7 limit stays", lim_sticky, 1);

        do_op(2'b01, 0, 24'h800000, 24'h7FFFFF);
        chk(cc_flags == 4'b0001, "R8 negative flag", cc_flags, 4'b0001);
        do_rd(0, 2'b00, w);
        chk(w == 24'h800001, "R2 negative product", w, 24'h800001);
        do_op(2'b11, 0, 24'h800000, 24'h800000);
        chk(cc_flags == 4'b1001, "R11 negative extension", cc_flags, 4'b1001);
        do_rd(0, 2'b00, w);
        chk(w == 24'h800000, "R6 negative clamp", w, 24'h800000);

        do_op(2'b00, 1, 24'h0, 24'h0);
        for (int i = 0; i < 255; i++) do_op(2'b10, 1, 24'h800000, 24'h800000);
        chk(cc_flags == 4'b1000, "R9 no overflow before wrap", cc_flags, 4'b1000);
        do_op(2'b10, 1, 24'h800000, 24'h800000);
        chk(cc_flags == 4'b1101, "R9 overflow on wrap", cc_flags, 4'b1101);
        do_rd(1, 2'b00, w);
        chk(w == 24'h800000, "R6 wrapped value clamps", w, 24'h800000);

        do_op(2'b00, 1, 24'h0, 24'h0);
        do_op(2'b01, 1, 24'h000C00, 24'h001000, 1'b1);
        chk(cc_flags == 4'b0000, "R10 flags after rounded write", cc_flags, 0);
        do_rd(1, 2'b10, w);
        chk(w == 24'h000004, "R10 low bits cleared", w, 4);
        do_rd(1, 2'b11, w);
        chk(w == 24'h000002, "R5 code 11 acts as none", w, 2);

        repeat (2) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end
endmodule